// File: doc/BRIEF.md
# Synchronous Short/Long Reset Sequencer

This block turns a filtered, active-low external reset line into an ordered system reset, counting in CPU clock periods (one TCL equals one `clk` cycle). The line first passes through a two-stage synchronizer. A request is accepted only if the synchronized line stays low for four consecutive cycles. A fixed twelve-cycle synchronization wait follows. Then a 1024-cycle internal sequence runs, during which `sys_rst` is held high. Eight cycles after that sequence the line is sampled once more. A high line marks the event Short. A low line marks it Long, and a Long result also opens a window in which three clock-option bits follow the configuration port.

When bidirectional mode is selected, the block pulls the reset pad low from acceptance to the end of the 1024-cycle sequence, so a brief pulse still produces a full-width reset. The block leaves reset only after two conditions hold: the line has returned high, and, when on-chip memory is the boot target, the memory reports that it has finished initializing. On the exit cycle it gives a one-cycle `cpu_start` pulse and captures the whole configuration port. While reset is in progress, the bus strobes are forced to their idle levels.

Top module: `sync_reset_sequencer`

## Requirements
- R1: A request is accepted only when the synchronized line reads low on 4 consecutive cycles. If the input is held low across only 3 sampling edges, nothing happens: `sys_rst` and `rstin_pull_low` stay 0 and the flags are unchanged.
- R2: Take the first rising edge that samples `rstin_filt_n` low as edge 0. `sys_rst` then rises after edge 17: two synchronizer stages, four qualification cycles, and a twelve-cycle wait.
- R3: The internal sequence lasts 1024 cycles. The classification sample is taken 8 cycles after the sequence ends, at edge 1049. Flags are unchanged before that edge.
- R4: If the synchronized line is high at the sample edge, only `short_flag` is set. If it is low, both `short_flag` and `long_flag` are set. An input first seen high at edge 1047 gives Short. An input first seen high at edge 1048 gives Long.
- R5: Flags are sticky across later events. `flag_clr` is write-one-to-clear, with bit 0 clearing `short_flag` and bit 1 clearing `long_flag`. A set and a clear in the same cycle leave the flag set.
- R6: A Long result raises `cfg_transparent`. While it is high, `clk_cfg` follows `cfg_port[15:13]` one cycle late. `cfg_transparent` falls 3 cycles after the first edge that samples the input high again. After that, `clk_cfg` holds its value.
- R7: When `bidir_en` is 1, `rstin_pull_low` is high from the cycle after acceptance until the end of the 1024-cycle sequence. When `bidir_en` is 0, it never rises.
- R8: Reset is extended for as long as the synchronized line stays low after the sample edge.
- R9: When `int_mem_sel` is 1, reset is further extended until `mem_init_done` is 1. `cpu_start` follows one cycle after `mem_init_done` is seen.
- R10: `sys_rst` falls on the same cycle that `cpu_start` rises. `cpu_start` lasts exactly one cycle. `sys_cfg` captures `cfg_port` at the end of that cycle. `boot_addr` reads 0x000000.
- R11: Outside normal running, `ale` is 0 and `rd_n` and `wr_n` are 1. During normal running, these outputs follow `cpu_ale`, `cpu_rd_n` and `cpu_wr_n`.
- R12: After `rst_n`, the outputs are as follows: `sys_rst`, `cpu_start`, both flags, `cfg_transparent`, `rstin_pull_low`, `clk_cfg` and `sys_cfg` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock, one TCL per cycle |
| rst_n | input | 1 | Synchronous active-low reset of the block itself |
| rstin_filt_n | input | 1 | Filtered external reset line, low requests reset |
| bidir_en | input | 1 | Enables pulling the reset pad low during the sequence |
| int_mem_sel | input | 1 | Boot from on-chip memory, wait for its initialization |
| mem_init_done | input | 1 | On-chip memory initialization finished |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 short, bit 1 long |
| cfg_port | input | 16 | Configuration port pins |
| cpu_ale | input | 1 | Address latch enable from the core |
| cpu_rd_n | input | 1 | Read strobe from the core |
| cpu_wr_n | input | 1 | Write strobe from the core |
| rstin_pull_low | output | 1 | Pull the reset pad low |
| sys_rst | output | 1 | Internal system reset |
| cpu_start | output | 1 | One-cycle pulse when execution may begin |
| short_flag | output | 1 | Sticky short-reset flag |
| long_flag | output | 1 | Sticky long-reset flag |
| cfg_transparent | output | 1 | Clock-option bits are following the port |
| clk_cfg | output | 3 | Clock options captured from `cfg_port[15:13]` |
| sys_cfg | output | 16 | Configuration captured at reset exit |
| boot_addr | output | 24 | First fetch address |
| ale | output | 1 | Address latch enable to the bus |
| rd_n | output | 1 | Read strobe to the bus |
| wr_n | output | 1 | Write strobe to the bus |

## Verification
The bench targets the qualification threshold with pulses of three and four cycles. A design with an off-by-one counter would either start a reset from a glitch or drop a legal request. It also targets the Short/Long boundary by releasing the line at edge 1047 and then at edge 1048. A sample taken one cycle early or late would swap the two flags. The transparency window is checked on both sides of its closing edge, and `clk_cfg` must freeze afterwards. A window that closes too early, or a latch that stays open, would let a late pin change alter the clock options. The bench also checks that an older Long flag survives a later Short event, that a set wins over a simultaneous clear, and that the pad pull is released exactly at the end of the 1024-cycle sequence.

// File: rtl/rstseq_pkg.sv
// Shared types for the reset sequencer.
// Assumes: the state encoding is used only inside the sequencer hierarchy.
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUALIFY,
        ST_SYNC_WAIT,
        ST_SEQUENCE,
        ST_SAMPLE_WAIT,
        ST_EXTEND,
        ST_MEM_INIT,
        ST_RUN
    } seq_state_e;

    localparam int FLAG_SHORT = 0;
    localparam int FLAG_LONG  = 1;
    localparam int FLAG_COUNT = 2;

endpackage

// File: rtl/rstseq_sync.sv
// Multi-stage synchronizer for the active-low filtered reset line.
// Assumes: the input is asynchronous and STAGES >= 2. During block reset the
// chain is preset high, which means no request.
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/rstseq_fsm.sv
// Sequencer state machine. It qualifies the request, waits for synchronization,
// runs the fixed sequence, samples the line to classify the event, and then
// extends reset until the line is high and memory is ready.
// Assumes: req_low is synchronous. A single counter covers every timed phase,
// so every tick count must be no larger than SEQ_TICKS, and QUAL_TICKS >= 2.
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int QUAL_TICKS   = 4,
    parameter int SYNC_TICKS   = 12,
    parameter int SEQ_TICKS    = 1024,
    parameter int SAMPLE_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_low,
    input  logic bidir_en,
    input  logic int_mem_sel,
    input  logic mem_init_done,
    output logic set_short,
    output logic set_long,
    output logic drive_low,
    output logic sys_rst,
    output logic cpu_start,
    output logic bus_quiet
);

    localparam int CNT_W = $clog2(SEQ_TICKS + 1);
    localparam logic [CNT_W-1:0] QUAL_LAST   = CNT_W'(QUAL_TICKS - 1);
    localparam logic [CNT_W-1:0] SYNC_LAST   = CNT_W'(SYNC_TICKS - 1);
    localparam logic [CNT_W-1:0] SEQ_LAST    = CNT_W'(SEQ_TICKS - 1);
    localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_TICKS - 1);

    seq_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // Next-state and counter decode; the classification pulses come from here.
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt + 1'b1;
        set_short = 1'b0;
        set_long  = 1'b0;
        case (state)
            ST_IDLE: begin
                cnt_nxt = '0;
                if (req_low) begin
                    state_nxt = ST_QUALIFY;
                    cnt_nxt   = CNT_W'(1);
                end
            end
            ST_QUALIFY: begin
                if (!req_low) begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                end else if (cnt == QUAL_LAST) begin
                    state_nxt = ST_SYNC_WAIT;
                    cnt_nxt   = '0;
                end
            end
            ST_SYNC_WAIT: begin
                if (cnt == SYNC_LAST) begin
                    state_nxt = ST_SEQUENCE;
                    cnt_nxt   = '0;
                end
            end
            ST_SEQUENCE: begin
                if (cnt == SEQ_LAST) begin
                    state_nxt = ST_SAMPLE_WAIT;
                    cnt_nxt   = '0;
                end
            end
            ST_SAMPLE_WAIT: begin
                if (cnt == SAMPLE_LAST) begin
                    state_nxt = ST_EXTEND;
                    cnt_nxt   = '0;
                    set_short = 1'b1;
                    set_long  = req_low;
                end
            end
            ST_EXTEND: begin
                cnt_nxt = '0;
                if (!req_low)
                    state_nxt = (int_mem_sel && !mem_init_done) ? ST_MEM_INIT : ST_RUN;
            end
            ST_MEM_INIT: begin
                cnt_nxt = '0;
                if (mem_init_done) state_nxt = ST_RUN;
            end
            ST_RUN: begin
                cnt_nxt   = '0;
                state_nxt = ST_IDLE;
            end
            default: begin
                cnt_nxt   = '0;
                state_nxt = ST_IDLE;
            end
        endcase
    end

    // State and tick counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Output decode from the registered state.
    always_comb begin
        sys_rst   = state inside {ST_SEQUENCE, ST_SAMPLE_WAIT, ST_EXTEND, ST_MEM_INIT};
        drive_low = bidir_en && (state inside {ST_SYNC_WAIT, ST_SEQUENCE});
        cpu_start = (state == ST_RUN);
        bus_quiet = (state != ST_IDLE);
    end

    p_qualify_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUALIFY && !req_low) |=> (state == ST_IDLE));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= SEQ_LAST));

    p_extend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXTEND && req_low) |=> (state == ST_EXTEND));

    p_mem_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEM_INIT && !mem_init_done) |=> (state == ST_MEM_INIT));

    p_start_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_start |=> !cpu_start);

endmodule

// File: rtl/rstseq_flags.sv
// Sticky reset-cause flags with per-bit write-one-to-clear.
// Assumes: a set and a clear in the same cycle leave the flag set.
module rstseq_flags #(
    parameter int N_FLAGS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] set,
    input  logic [N_FLAGS-1:0] clr,
    output logic [N_FLAGS-1:0] flags
);

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        // One sticky bit per cause.
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end

        p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[i]) |-> $past(clr[i]));
    end

endmodule

// File: rtl/rstseq_cfg.sv
// Configuration capture. A Long result opens a transparency window in which
// the clock-option slice follows the port. The window closes HOLD_TICKS cycles
// after the synchronized line reads high. The full port is latched on exit.
// Assumes: req_low is already synchronized, so the two synchronizer stages add
// to HOLD_TICKS in the externally visible closing delay.
module rstseq_cfg #(
    parameter int CFG_W      = 16,
    parameter int CLK_LSB    = 13,
    parameter int CLK_W      = 3,
    parameter int HOLD_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic             req_low,
    input  logic             exit_now,
    input  logic [CFG_W-1:0] cfg_port,
    output logic             transparent,
    output logic [CLK_W-1:0] clk_cfg,
    output logic [CFG_W-1:0] sys_cfg
);

    localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_TICKS - 1);

    logic [HOLD_W-1:0] hcnt;

    // Window open/close with the closing delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            transparent <= 1'b0;
            hcnt        <= '0;
        end else if (open_req) begin
            transparent <= 1'b1;
            hcnt        <= '0;
        end else if (transparent) begin
            if (req_low) begin
                hcnt <= '0;
            end else if (hcnt == HOLD_LAST) begin
                transparent <= 1'b0;
                hcnt        <= '0;
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    // Clock-option slice follows the port only while the window is open.
    always_ff @(posedge clk) begin
        if (!rst_n)           clk_cfg <= '0;
        else if (transparent) clk_cfg <= cfg_port[CLK_LSB +: CLK_W];
    end

    // Whole-port capture on the exit cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        sys_cfg <= '0;
        else if (exit_now) sys_cfg <= cfg_port;
    end

    p_window_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(transparent) |-> $past(!req_low));

    p_clk_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!transparent) |=> $stable(clk_cfg));

endmodule

// File: rtl/sync_reset_sequencer.sv
// Top of the reset sequencer. It wires the synchronizer, the state machine,
// the flags and the configuration capture together, and gates the bus strobes.
// Assumes: one clk cycle equals one TCL, and rstin_filt_n has already passed
// through the analog filter.
module sync_reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int          SYNC_STAGES    = 2,
    parameter int          QUAL_TICKS     = 4,
    parameter int          SYNC_TICKS     = 12,
    parameter int          SEQ_TICKS      = 1024,
    parameter int          SAMPLE_TICKS   = 8,
    parameter int          CFG_HOLD_TICKS = 2,
    parameter int          CFG_W          = 16,
    parameter int          CLK_LSB        = 13,
    parameter int          CLK_W          = 3,
    parameter int          ADDR_W         = 24,
    parameter logic [23:0] BOOT_ADDR      = 24'h00_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rstin_filt_n,
    input  logic             bidir_en,
    input  logic             int_mem_sel,
    input  logic             mem_init_done,
    input  logic [1:0]       flag_clr,
    input  logic [CFG_W-1:0] cfg_port,
    input  logic             cpu_ale,
    input  logic             cpu_rd_n,
    input  logic             cpu_wr_n,
    output logic             rstin_pull_low,
    output logic             sys_rst,
    output logic             cpu_start,
    output logic             short_flag,
    output logic             long_flag,
    output logic             cfg_transparent,
    output logic [CLK_W-1:0] clk_cfg,
    output logic [CFG_W-1:0] sys_cfg,
    output logic [ADDR_W-1:0] boot_addr,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n
);

    logic                  line_sync;
    logic                  req_low;
    logic                  set_short, set_long;
    logic                  bus_quiet;
    logic [FLAG_COUNT-1:0] flag_set, flag_vec;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rstin_filt_n),
        .sync_out (line_sync)
    );

    assign req_low = !line_sync;

    rstseq_fsm #(
        .QUAL_TICKS   (QUAL_TICKS),
        .SYNC_TICKS   (SYNC_TICKS),
        .SEQ_TICKS    (SEQ_TICKS),
        .SAMPLE_TICKS (SAMPLE_TICKS)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_low       (req_low),
        .bidir_en      (bidir_en),
        .int_mem_sel   (int_mem_sel),
        .mem_init_done (mem_init_done),
        .set_short     (set_short),
        .set_long      (set_long),
        .drive_low     (rstin_pull_low),
        .sys_rst       (sys_rst),
        .cpu_start     (cpu_start),
        .bus_quiet     (bus_quiet)
    );

    // Map the classification pulses onto flag positions.
    always_comb begin
        flag_set             = '0;
        flag_set[FLAG_SHORT] = set_short;
        flag_set[FLAG_LONG]  = set_long;
    end

    rstseq_flags #(.N_FLAGS(FLAG_COUNT)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .flags (flag_vec)
    );

    assign short_flag = flag_vec[FLAG_SHORT];
    assign long_flag  = flag_vec[FLAG_LONG];

    rstseq_cfg #(
        .CFG_W      (CFG_W),
        .CLK_LSB    (CLK_LSB),
        .CLK_W      (CLK_W),
        .HOLD_TICKS (CFG_HOLD_TICKS)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_req    (set_long),
        .req_low     (req_low),
        .exit_now    (cpu_start),
        .cfg_port    (cfg_port),
        .transparent (cfg_transparent),
        .clk_cfg     (clk_cfg),
        .sys_cfg     (sys_cfg)
    );

    // Bus strobes sit at idle levels whenever the sequencer is not running.
    always_comb begin
        ale  = bus_quiet ? 1'b0 : cpu_ale;
        rd_n = bus_quiet ? 1'b1 : cpu_rd_n;
        wr_n = bus_quiet ? 1'b1 : cpu_wr_n;
    end

    assign boot_addr = BOOT_ADDR[ADDR_W-1:0];

    p_bus_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> (!ale && rd_n && wr_n));

    p_exit_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> cpu_start);

    p_pull_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rstin_pull_low |-> bidir_en);

    p_long_with_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(long_flag) |-> short_flag);

endmodule

// File: tb/sim_sync_reset_sequencer.sv
// Directed bench for the reset sequencer. Inputs change and outputs are read
// on falling edges. Index n counts the rising edges seen since the press began.
module sim_sync_reset_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        press = 1'b0;
    logic        bidir_en = 1'b0;
    logic        int_mem_sel = 1'b0;
    logic        mem_init_done = 1'b0;
    logic [1:0]  flag_clr = 2'b00;
    logic [15:0] cfg_port = 16'h0000;
    logic        cpu_ale = 1'b0, cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
    logic        rstin_filt_n;
    logic        rstin_pull_low, sys_rst, cpu_start, short_flag, long_flag;
    logic        cfg_transparent, ale, rd_n, wr_n;
    logic [2:0]  clk_cfg;
    logic [15:0] sys_cfg;
    logic [23:0] boot_addr;

    int checks = 0;
    int errors = 0;
    int n = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Pad model: the external source or the block's own pull drives it low.
    assign rstin_filt_n = !(press || rstin_pull_low);

    sync_reset_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .rstin_filt_n(rstin_filt_n),
        .bidir_en(bidir_en), .int_mem_sel(int_mem_sel),
        .mem_init_done(mem_init_done), .flag_clr(flag_clr),
        .cfg_port(cfg_port), .cpu_ale(cpu_ale), .cpu_rd_n(cpu_rd_n),
        .cpu_wr_n(cpu_wr_n), .rstin_pull_low(rstin_pull_low),
        .sys_rst(sys_rst), .cpu_start(cpu_start), .short_flag(short_flag),
        .long_flag(long_flag), .cfg_transparent(cfg_transparent),
        .clk_cfg(clk_cfg), .sys_cfg(sys_cfg), .boot_addr(boot_addr),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic adv_to(input int target);
        while (n < target) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic start_press();
        @(negedge clk);
        press = 1'b1;
        n = 0;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        flag_clr = 2'b11;
        @(negedge clk);
        flag_clr = 2'b00;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R12 sys_rst", sys_rst, 0);
        chk("R12 cpu_start", cpu_start, 0);
        chk("R12 flags", {short_flag, long_flag}, 0);
        chk("R12 pull", rstin_pull_low, 0);
        chk("R12 transparent", cfg_transparent, 0);
        chk("R12 clk_cfg", clk_cfg, 0);
        chk("R12 sys_cfg", sys_cfg, 0);
        chk("R10 boot_addr", boot_addr, 0);
        cpu_ale = 1'b1; cpu_rd_n = 1'b0; cpu_wr_n = 1'b1;
        @(negedge clk);
        chk("R11 passthrough ale", ale, 1);
        chk("R11 passthrough rd_n", rd_n, 0);
    endtask

    task automatic t_reject();
        int seen = 0;
        start_press();
        adv_to(3);
        press = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sys_rst || rstin_pull_low) seen++;
        end
        chk("R1 three-cycle pulse ignored", seen, 0);
        chk("R1 flags untouched", {short_flag, long_flag}, 0);
    endtask

    task automatic t_short();
        cfg_port = 16'hA5C3;
        start_press();
        adv_to(4);
        press = 1'b0;
        adv_to(17);
        chk("R2 sys_rst before edge 17", sys_rst, 0);
        adv_to(18);
        chk("R2 sys_rst after edge 17", sys_rst, 1);
        chk("R11 ale forced", ale, 0);
        chk("R11 rd_n forced", rd_n, 1);
        chk("R11 wr_n forced", wr_n, 1);
        adv_to(1049);
        chk("R3 no flag before sample", short_flag, 0);
        adv_to(1050);
        chk("R4 short set", short_flag, 1);
        chk("R4 long clear", long_flag, 0);
        chk("R6 no window on short", cfg_transparent, 0);
        adv_to(1051);
        chk("R10 cpu_start", cpu_start, 1);
        chk("R10 sys_rst released", sys_rst, 0);
        adv_to(1052);
        chk("R10 pulse one cycle", cpu_start, 0);
        chk("R10 sys_cfg latched", sys_cfg, 16'hA5C3);
        chk("R11 ale follows core", ale, 1);
        settle();
        clear_flags();
    endtask

    task automatic t_boundary();
        start_press();
        adv_to(1047);
        press = 1'b0;
        adv_to(1050);
        chk("R4 edge 1047 gives short", short_flag, 1);
        chk("R4 edge 1047 no long", long_flag, 0);
        settle();
        clear_flags();
        start_press();
        adv_to(1048);
        press = 1'b0;
        adv_to(1050);
        chk("R4 edge 1048 gives long", long_flag, 1);
        chk("R6 window open", cfg_transparent, 1);
        adv_to(1052);
        chk("R6 window closed", cfg_transparent, 0);
        settle();
        clear_flags();
    endtask

    task automatic t_long_cfg();
        cfg_port = 16'hA000;
        start_press();
        adv_to(1050);
        chk("R4 long held", long_flag, 1);
        chk("R6 transparent", cfg_transparent, 1);
        adv_to(1100);
        chk("R8 still in reset", sys_rst, 1);
        chk("R6 clk_cfg tracks", clk_cfg, 5);
        cfg_port = 16'h6000;
        adv_to(1102);
        chk("R6 clk_cfg retracks", clk_cfg, 3);
        adv_to(1200);
        press = 1'b0;
        adv_to(1203);
        chk("R8 exit after release", cpu_start, 1);
        chk("R6 open at edge R+2", cfg_transparent, 1);
        adv_to(1204);
        chk("R6 closed at edge R+3", cfg_transparent, 0);
        cfg_port = 16'hC000;
        adv_to(1207);
        chk("R6 clk_cfg frozen", clk_cfg, 3);
        settle();
    endtask

    task automatic t_sticky();
        start_press();
        adv_to(4);
        press = 1'b0;
        adv_to(1048);
        flag_clr = 2'b01;
        adv_to(1050);
        flag_clr = 2'b00;
        chk("R5 set beats clear", short_flag, 1);
        chk("R5 old long survives", long_flag, 1);
        settle();
        flag_clr = 2'b10;
        @(negedge clk);
        flag_clr = 2'b00;
        chk("R5 long cleared", long_flag, 0);
        chk("R5 short kept", short_flag, 1);
        flag_clr = 2'b01;
        @(negedge clk);
        flag_clr = 2'b00;
        chk("R5 short cleared", short_flag, 0);
    endtask

    task automatic t_bidir();
        bidir_en = 1'b1;
        start_press();
        adv_to(4);
        press = 1'b0;
        adv_to(5);
        chk("R7 no pull before accept", rstin_pull_low, 0);
        adv_to(6);
        chk("R7 pull after accept", rstin_pull_low, 1);
        adv_to(600);
        chk("R7 pull mid sequence", rstin_pull_low, 1);
        adv_to(1041);
        chk("R7 pull last cycle", rstin_pull_low, 1);
        adv_to(1042);
        chk("R7 pull released", rstin_pull_low, 0);
        adv_to(1050);
        chk("R7 stretched pulse short", short_flag, 1);
        chk("R7 stretched pulse not long", long_flag, 0);
        adv_to(1051);
        chk("R10 bidir exit", cpu_start, 1);
        bidir_en = 1'b0;
        settle();
        clear_flags();
    endtask

    task automatic t_mem();
        int_mem_sel = 1'b1;
        mem_init_done = 1'b0;
        start_press();
        adv_to(4);
        press = 1'b0;
        adv_to(1051);
        chk("R9 waits for memory", sys_rst, 1);
        chk("R9 no start yet", cpu_start, 0);
        adv_to(1100);
        chk("R9 still waiting", sys_rst, 1);
        mem_init_done = 1'b1;
        adv_to(1101);
        chk("R9 start after done", cpu_start, 1);
        mem_init_done = 1'b0;
        int_mem_sel = 1'b0;
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_reject();
        t_short();
        t_boundary();
        t_long_cfg();
        t_sticky();
        t_bidir();
        t_mem();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule